// File: doc/BRIEF.md
# Open-Row DRAM Bank Timing Controller

This block is a cycle-level timing model of a banked DRAM read path. It takes one read request per cycle. It splits the request address into a bank index and a row index, and it keeps one open row for each bank. From that state it works out the cycle in which the data would be ready. In that cycle it emits a fill response that carries the original address, the requester's tag, a data word derived from the address, and a flag that tells whether the access found its row already open.

Latency is counted against a free-running cycle counter. An access to the open row of its bank completes after the column latency plus the burst length. Any other access pays precharge, activate, column latency and burst. That sum is counted from the later of two times: the acceptance cycle, or the cycle until which the bank is still busy from its previous access. Up to a fixed number of accepted requests wait in a small age-ordered pool until their completion cycle arrives. Two running counters record how many accesses hit an open row and how many missed.

Top module: `dram_bank_timer`

## Requirements
- R1: The bank index is address bits [12:10], so there are 8 banks. The row index is address bits [26:13], a 14-bit value. No other address bit affects timing or the row-hit decision.
- R2: After reset no bank has an open row, so the first access to each bank is a miss.
- R3: A request accepted in the cycle where the internal counter reads T, that targets the open row of its bank, becomes due at T + T_CAS + T_BURST (default 19 cycles). It does not wait for the bank's busy time.
- R4: Any other accepted request becomes due at max(T, bank busy-until) + T_RP + T_RCD + T_CAS + T_BURST (default 49 cycles after the start).
- R5: Every accepted request makes its row the bank's open row and sets the bank's busy-until to that request's due cycle.
- R6: hit_count increases by one for each accepted row hit, and miss_count increases by one for each accepted miss. Neither changes in a cycle with no acceptance.
- R7: A response drives rsp_addr and rsp_tag equal to the request's values, rsp_data = address XOR 0x5A5A5A5A, and rsp_row_hit = 1 for a hit and 0 for a miss.
- R8: A request is accepted only when req_valid and req_ready are both 1. req_ready is 0 exactly while 8 accepted requests have not yet responded.
- R9: rsp_valid is 1 for one cycle per request, in the first cycle at or after its due cycle in which no older accepted request is also due. Due requests leave one per cycle, in acceptance order.
- R10: During and right after reset, req_ready is 1, rsp_valid is 0, and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Room for another in-flight request |
| req_addr | input | 32 | Request byte address |
| req_tag | input | 4 | Requester tag returned with the response |
| rsp_valid | output | 1 | Fill response present this cycle |
| rsp_addr | output | 32 | Address of the request being answered |
| rsp_tag | output | 4 | Tag of the request being answered |
| rsp_data | output | 32 | Fill word derived from the address |
| rsp_row_hit | output | 1 | Request found its row open |
| hit_count | output | 16 | Accepted row hits since reset |
| miss_count | output | 16 | Accepted row misses since reset |

## Verification
Two completions can fall due in the same cycle. One case is a miss accepted at T followed by a hit to another, already open bank accepted at T+30: both are due at T+49. The bench builds that case on purpose. It expects the older miss at T+49 and the younger hit one cycle later. Random traffic concentrated on three rows across all eight banks produces many more such collisions, and these pile up against the 8-entry limit. A bench reference model keeps its own due cycles and acceptance order and predicts every cycle's response and ready value.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  localparam int TIME_W = 32;
  typedef logic [TIME_W-1:0] time_t;

  // True when the counter value now is at or past the cycle due (wrap safe).
  function automatic logic reached(input time_t now, input time_t due);
    time_t diff;
    diff = now - due;
    return ~diff[TIME_W-1];
  endfunction

  // The later of two cycle stamps (wrap safe).
  function automatic time_t later_of(input time_t a, input time_t b);
    time_t diff;
    diff = b - a;
    return (diff[TIME_W-1] || (diff == '0)) ? a : b;
  endfunction

  // Completion cycle of an access accepted at now.
  function automatic time_t access_due(input time_t now, input time_t busy,
                                       input logic hit, input time_t hit_lat,
                                       input time_t miss_lat);
    return hit ? (now + hit_lat) : (later_of(now, busy) + miss_lat);
  endfunction

endpackage

// File: rtl/dbt_bank_table.sv
module dbt_bank_table
  import dbt_pkg::*;
#(
  parameter int unsigned BANK_W   = 3,
  parameter int unsigned ROW_W    = 14,
  parameter int unsigned HIT_LAT  = 19,
  parameter int unsigned MISS_LAT = 49
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [ROW_W-1:0]  row_sel,
  input  time_t             now,
  output logic              row_hit,
  output time_t             due
);

  localparam int unsigned NBANK = 1 << BANK_W;

  logic [NBANK-1:0] open_v;
  logic [ROW_W-1:0] open_row [NBANK];
  time_t            busy     [NBANK];

  assign row_hit = open_v[bank_sel] && (open_row[bank_sel] == row_sel);
  assign due     = access_due(now, busy[bank_sel], row_hit,
                              time_t'(HIT_LAT), time_t'(MISS_LAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_v <= '0;
      for (int b = 0; b < NBANK; b++) begin
        open_row[b] <= '0;
        busy[b]     <= '0;
      end
    end else if (acc) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bank_sel == BANK_W'(b)) begin
          open_v[b]   <= 1'b1;
          open_row[b] <= row_sel;
          busy[b]     <= due;
        end
      end
    end
  end

  AST_MISS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !row_hit) |-> ((due - now) >= time_t'(MISS_LAT))); // R4

  AST_HIT_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && row_hit) |-> ((due - now) < time_t'(MISS_LAT))); // R3

endmodule

// File: rtl/dbt_pending_queue.sv
module dbt_pending_queue
  import dbt_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  time_t             now,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              push_hit,
  input  time_t             push_due,
  output logic              full,
  output logic              pop_valid,
  output logic [ADDR_W-1:0] pop_addr,
  output logic [TAG_W-1:0]  pop_tag,
  output logic              pop_hit
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
    logic              hit;
    time_t             due;
  } ent_t;

  // Slot 0 holds the oldest entry; slots are kept compact.
  ent_t             slot_q [DEPTH];
  ent_t             slot_d [DEPTH];
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic [CNT_W-1:0] tail;
  logic [DEPTH-1:0] ripe;
  logic [IDX_W-1:0] pick;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ripe
    assign ripe[i] = (CNT_W'(i) < count_q) && reached(now, slot_q[i].due);
  end

  always_comb begin
    pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ripe[i]) pick = IDX_W'(i);
    end
  end

  assign pop_valid = |ripe;
  assign pop_addr  = slot_q[pick].addr;
  assign pop_tag   = slot_q[pick].tag;
  assign pop_hit   = slot_q[pick].hit;
  assign full      = (count_q == CNT_W'(DEPTH));
  assign tail      = count_q - CNT_W'(pop_valid);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (pop_valid) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pick) slot_d[i] = slot_q[i + 1];
      end
    end
    if (push) begin
      slot_d[tail[IDX_W-1:0]] = '{addr: push_addr, tag: push_tag,
                                  hit: push_hit, due: push_due};
    end
    count_d = count_q + CNT_W'(push) - CNT_W'(pop_valid);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      count_q <= count_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < CNT_W'(DEPTH))); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((count_q == $past(count_q)) ||
              (count_q == $past(count_q) + 1'b1) ||
              (count_q + 1'b1 == $past(count_q)))); // R9

endmodule

// File: rtl/dbt_perf_counters.sv
module dbt_perf_counters #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             hit,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else if (acc) begin
      if (hit) hit_count  <= hit_count + 1'b1;
      else     miss_count <= miss_count + 1'b1;
    end
  end

  AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((hit_count != $past(hit_count)) ^ (miss_count != $past(miss_count)))); // R6

  AST_IDLE_COUNTERS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(hit_count) && $stable(miss_count))); // R6

endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dbt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned BANK_LSB = 10,
  parameter int unsigned BANK_W   = 3,
  parameter int unsigned ROW_LSB  = 13,
  parameter int unsigned ROW_W    = 14,
  parameter int unsigned T_CAS    = 15,
  parameter int unsigned T_BURST  = 4,
  parameter int unsigned T_RP     = 15,
  parameter int unsigned T_RCD    = 15,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned CNT_W    = 16,
  parameter logic [ADDR_W-1:0] FILL_MASK = 32'h5A5A_5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [ADDR_W-1:0] rsp_data,
  output logic              rsp_row_hit,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int unsigned HIT_LAT  = T_CAS + T_BURST;
  localparam int unsigned MISS_LAT = T_RP + T_RCD + HIT_LAT;

  time_t             now_q;
  logic              accept;
  logic              q_full;
  logic              row_hit;
  time_t             due;
  logic [BANK_W-1:0] bank_sel;
  logic [ROW_W-1:0]  row_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  assign bank_sel  = req_addr[BANK_LSB +: BANK_W];
  assign row_sel   = req_addr[ROW_LSB +: ROW_W];
  assign req_ready = !q_full;
  assign accept    = req_valid && req_ready;
  assign rsp_data  = rsp_addr ^ FILL_MASK;

  dbt_bank_table #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
  ) u_banks (
    .clk(clk), .rst_n(rst_n), .acc(accept), .bank_sel(bank_sel),
    .row_sel(row_sel), .now(now_q), .row_hit(row_hit), .due(due)
  );

  dbt_pending_queue #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n), .now(now_q), .push(accept),
    .push_addr(req_addr), .push_tag(req_tag), .push_hit(row_hit),
    .push_due(due), .full(q_full), .pop_valid(rsp_valid),
    .pop_addr(rsp_addr), .pop_tag(rsp_tag), .pop_hit(rsp_row_hit)
  );

  dbt_perf_counters #(
    .CNT_W(CNT_W)
  ) u_counts (
    .clk(clk), .rst_n(rst_n), .acc(accept), .hit(row_hit),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && req_ready)); // R10

endmodule

// File: tb/dram_bank_timer_bench.sv
module dram_bank_timer_bench;

  localparam int HIT_L  = 19;
  localparam int MISS_L = 49;
  localparam int QMAX   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_tag = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic [3:0]  rsp_tag;
  logic [31:0] rsp_data;
  logic        rsp_row_hit;
  logic [15:0] hit_count;
  logic [15:0] miss_count;

  always #10 clk = ~clk;

  dram_bank_timer u_dram_bank_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .rsp_row_hit(rsp_row_hit), .hit_count(hit_count), .miss_count(miss_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  // reference model state
  bit          b_open [8];
  int          b_row  [8];
  int          b_busy [8];
  logic [31:0] p_addr [16];
  logic [3:0]  p_tag  [16];
  int          p_due  [16];
  bit          p_hit  [16];
  int          p_n = 0;
  int          m_hits = 0;
  int          m_miss = 0;
  logic [3:0]  next_tag = 0;

  function automatic int bank_of(input logic [31:0] a);
    return int'((a >> 10) & 32'h7);
  endfunction

  function automatic int row_of(input logic [31:0] a);
    return int'((a >> 13) & 32'h3FFF);
  endfunction

  function automatic int due_of(input bit hit, input int t, input int busy);
    if (hit) return t + HIT_L;
    return ((busy > t) ? busy : t) + MISS_L;
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // One cycle: check outputs at the negedge, then offer a request.
  task automatic step(input bit do_req, input logic [31:0] a);
    int  sel;
    bit  exp_ready;
    sel = -1;
    for (int i = 0; i < p_n; i++) begin
      if (sel < 0 && p_due[i] <= cyc) sel = i;
    end
    exp_ready = (p_n < QMAX);
    if (sel >= 0 || rsp_valid) begin
      chk(rsp_valid == (sel >= 0), "R3/R4/R9 rsp_valid timing",
          64'(rsp_valid), 64'(sel >= 0));
    end
    if (sel >= 0 && rsp_valid) begin
      chk(rsp_addr == p_addr[sel], "R7/R9 rsp_addr", 64'(rsp_addr), 64'(p_addr[sel]));
      chk(rsp_tag == p_tag[sel], "R7 rsp_tag", 64'(rsp_tag), 64'(p_tag[sel]));
      chk(rsp_data == (p_addr[sel] ^ 32'h5A5A_5A5A), "R7 rsp_data",
          64'(rsp_data), 64'(p_addr[sel] ^ 32'h5A5A_5A5A));
      chk(rsp_row_hit == p_hit[sel], "R1/R2/R5 rsp_row_hit",
          64'(rsp_row_hit), 64'(p_hit[sel]));
    end
    if (sel >= 0) begin
      for (int i = sel; i < p_n - 1; i++) begin
        p_addr[i] = p_addr[i+1]; p_tag[i] = p_tag[i+1];
        p_due[i]  = p_due[i+1];  p_hit[i] = p_hit[i+1];
      end
      p_n--;
    end
    req_valid = do_req;
    req_addr  = a;
    req_tag   = next_tag;
    if (do_req) begin
      chk(req_ready == exp_ready, "R8 req_ready", 64'(req_ready), 64'(exp_ready));
      if (exp_ready) begin
        int bk; int rw; bit h;
        bk = bank_of(a); rw = row_of(a);
        h = b_open[bk] && (b_row[bk] == rw);
        p_addr[p_n] = a; p_tag[p_n] = next_tag; p_hit[p_n] = h;
        p_due[p_n]  = due_of(h, cyc, b_busy[bk]);
        b_open[bk] = 1'b1; b_row[bk] = rw; b_busy[bk] = p_due[p_n];
        p_n++;
        if (h) m_hits++; else m_miss++;
        next_tag = next_tag + 1'b1;
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (p_n > 0 && guard < 2000) begin
      step(1'b0, '0);
      guard++;
    end
    repeat (3) step(1'b0, '0);
  endtask

  task automatic check_counts(input string where);
    chk(hit_count == 16'(m_hits), {"R6 hit_count ", where}, 64'(hit_count), 64'(m_hits));
    chk(miss_count == 16'(m_miss), {"R6 miss_count ", where}, 64'(miss_count), 64'(m_miss));
  endtask

  function automatic logic [31:0] mk(input int bk, input int rw, input logic [31:0] junk);
    logic [31:0] a;
    a = junk;
    a[12:10] = 3'(bk);
    a[26:13] = 14'(rw);
    return a;
  endfunction

  initial begin
    for (int b = 0; b < 8; b++) begin b_open[b] = 0; b_row[b] = 0; b_busy[b] = 0; end
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready in reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    cyc = 0;
    chk(hit_count == 0 && miss_count == 0, "R10 counters after reset",
        {hit_count, miss_count}, 64'd0);

    // R2, R3: cold miss then a hit on the same row with other low bits
    step(1'b1, mk(0, 5, 32'h0000_0040));
    drain();
    // R1: differing bits outside [26:10] still hit the open row
    step(1'b1, mk(0, 5, 32'hF800_0384));
    drain();
    check_counts("directed hit/miss");

    // R4, R5: back-to-back misses on one bank wait for busy-until
    step(1'b1, mk(2, 1, 32'h0));
    step(1'b1, mk(2, 2, 32'h0));
    step(1'b1, mk(2, 2, 32'h8)); // hit on newly opened row, R3 no busy wait
    drain();

    // R9: miss at T and hit at T+30 on another bank, both due T+49
    step(1'b1, mk(1, 7, 32'h0));
    drain();
    step(1'b1, mk(0, 9, 32'h0));
    repeat (29) step(1'b0, '0);
    step(1'b1, mk(1, 7, 32'h10));
    drain();

    // R8: ten back-to-back hits against an 8-deep pool
    step(1'b1, mk(3, 4, 32'h0));
    drain();
    for (int i = 0; i < 10; i++) step(1'b1, mk(3, 4, 32'(i * 4)));
    drain();
    check_counts("after directed");

    // random traffic on few rows to mix hits, misses and collisions
    for (int i = 0; i < 3000; i++) begin
      bit go;
      go = ($urandom_range(0, 9) < 7);
      step(go, mk(int'($urandom_range(0, 7)), int'($urandom_range(0, 2)), $urandom));
    end
    drain();
    check_counts("after random");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule